// File: doc/BRIEF.md
# Two-Queue Egress Scheduler with Head-Age Overrides

This block decides, one packet at a time, whether an egress port next serves its high-priority queue or its low-priority queue. The transmitter pulses a request when it is ready for another packet. One clock later the block answers with a single-cycle grant that names the queue. If both queues are empty, it answers with nothing.

With both queues backlogged and no special condition present, the block runs a weighted round robin. It grants up to W high-priority packets, then one low-priority packet, and then repeats. W is taken from a configuration input while reset is held, and the low weight is always one. Four conditions override that rotation:

- A high-priority head packet flagged with low drop precedence is always sent first.
- A high-priority head that has aged to the old threshold (2000 time units, one unit per microsecond) wins.
- A congested low queue wins while the high head is still younger than 1000 units.
- A full low queue wins while the high head is younger than 2000 units.

The age of the high head is the free-running time input minus the head's arrival stamp, computed modulo the counter width. Packet storage, classification and drop decisions live outside this block.

Top module: `egress_two_q_sched`

## Requirements
- R1: While reset is held and in the first cycle after it, grant_valid is 0, and the round-robin count starts at zero.
- R2: With both queues non-empty and no override active, the grants for a weight W from 1 to 16 repeat the pattern of W high grants (grant_sel = 0) followed by one low grant (grant_sel = 1).
- R3: With a weight of 0, both queues non-empty and no override active, every grant names the low queue.
- R4: An empty queue is never granted. When only one queue is non-empty, that queue is granted regardless of the round-robin count. When both are empty, a request gets no grant.
- R5: When both queues are non-empty and the high head carries the low-drop-precedence flag, the high queue is granted even if the low queue is congested or full.
- R6: When the high head's age is 2000 or more, the high queue is granted even if the low queue is congested or full.
- R7: When the high head's age is below 1000 and the low queue is congested, the low queue is granted.
- R8: When the high head's age is below 2000 and the low queue is full, the low queue is granted. A congested but not full low queue with a head age from 1000 to 1999 falls through to the round robin.
- R9: Age is computed as (time_now − hi_head_stamp) modulo 2^16, so a time counter that has wrapped past zero still gives the true age.
- R10: grant_valid rises in the cycle after a sampled tx_req and lasts one cycle. No grant is issued without a request.
- R11: The weight is captured from cfg_hi_weight while rst is high. Values above 16 are clamped to 16, and changes to the input after reset have no effect.
- R12: Every high grant, whatever its cause, advances the round-robin count, which saturates at W. Every low grant, whatever its cause, clears the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; the weight is captured while it is high |
| cfg_hi_weight | input | 5 | High-priority weight, 0 to 16 |
| tx_req | input | 1 | Transmitter asks for the next packet |
| hi_nonempty | input | 1 | High queue holds at least one packet |
| lo_nonempty | input | 1 | Low queue holds at least one packet |
| hi_low_drop | input | 1 | High head packet has low drop precedence |
| lo_congested | input | 1 | Low queue is congested |
| lo_full | input | 1 | Low queue is full |
| hi_head_stamp | input | 16 | Arrival time of the high head packet |
| time_now | input | 16 | Free-running time, one unit per microsecond |
| grant_valid | output | 1 | One-cycle grant strobe |
| grant_sel | output | 1 | Queue granted: 0 = high, 1 = low |

## Verification
The hardest situation to reach is an override that lands while the round-robin count sits partway through its cycle, because the count is visible only through the order of later grants. The stimulus reaches it by first issuing a known number of plain grants after reset. It then applies an override and checks the following grant sequence against a count model kept in the bench. The age boundaries at 999, 1000, 1999 and 2000 are swept against every combination of the congested, full and low-drop flags. The time counter is also placed just past its wrap point to exercise the modular age.

// File: rtl/dqs_pkg.sv
package dqs_pkg;
   typedef enum logic {
      Q_HI = 1'b0,
      Q_LO = 1'b1
   } qsel_e;

   typedef enum logic [2:0] {
      WHY_NONE,
      WHY_ONLY,
      WHY_LOWDROP,
      WHY_OLD,
      WHY_CONGEST,
      WHY_FULL,
      WHY_RR
   } why_e;
endpackage

// File: rtl/dqs_head_age.sv
module dqs_head_age #(
   parameter int TIME_W   = 16,
   parameter int YOUNG_US = 1000,
   parameter int OLD_US   = 2000
) (
   input  logic [TIME_W-1:0] now_i,
   input  logic [TIME_W-1:0] stamp_i,
   output logic              young_o,
   output logic              old_o
);
   localparam logic [TIME_W-1:0] YOUNG_T = TIME_W'(YOUNG_US);
   localparam logic [TIME_W-1:0] OLD_T   = TIME_W'(OLD_US);

   if (YOUNG_US >= OLD_US) begin : g_bad_order
      $error("dqs_head_age: young threshold must be below old threshold");
   end
   if (OLD_US >= (2 ** (TIME_W - 1))) begin : g_bad_range
      $error("dqs_head_age: old threshold exceeds half the time range");
   end

   logic [TIME_W-1:0] age;

   always_comb begin
      age     = now_i - stamp_i;
      young_o = (age < YOUNG_T);
      old_o   = (age >= OLD_T);
   end
endmodule

// File: rtl/dqs_rr_count.sv
module dqs_rr_count #(
   parameter int WEIGHT_W   = 5,
   parameter int WEIGHT_MAX = 16
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [WEIGHT_W-1:0] cfg_weight_i,
   input  logic                took_hi_i,
   input  logic                took_lo_i,
   output logic                want_lo_o
);
   localparam logic [WEIGHT_W-1:0] WMAX = WEIGHT_W'(WEIGHT_MAX);

   if (WEIGHT_MAX >= (2 ** WEIGHT_W)) begin : g_bad_weight
      $error("dqs_rr_count: weight limit does not fit the weight width");
   end

   logic [WEIGHT_W-1:0] weight_q;
   logic [WEIGHT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         weight_q <= (cfg_weight_i > WMAX) ? WMAX : cfg_weight_i;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (took_lo_i) begin
         cnt_q <= '0;
      end else if (took_hi_i && (cnt_q < weight_q)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign want_lo_o = (cnt_q >= weight_q);

   AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= weight_q); // R12
   AST_LOW_CLEARS: assert property (@(posedge clk) disable iff (rst)
      took_lo_i |=> (cnt_q == '0)); // R12
   AST_WEIGHT_HELD: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> $stable(weight_q)); // R11
endmodule

// File: rtl/dqs_pick.sv
module dqs_pick
   import dqs_pkg::*;
(
   input  logic  hi_ne_i,
   input  logic  lo_ne_i,
   input  logic  hi_low_drop_i,
   input  logic  lo_cong_i,
   input  logic  lo_full_i,
   input  logic  young_i,
   input  logic  old_i,
   input  logic  rr_want_lo_i,
   output logic  any_o,
   output qsel_e sel_o,
   output why_e  why_o
);
   always_comb begin
      any_o = hi_ne_i | lo_ne_i;
      sel_o = Q_HI;
      why_o = WHY_NONE;
      if (!any_o) begin
         why_o = WHY_NONE;
      end else if (!lo_ne_i) begin
         sel_o = Q_HI;
         why_o = WHY_ONLY;
      end else if (!hi_ne_i) begin
         sel_o = Q_LO;
         why_o = WHY_ONLY;
      end else if (hi_low_drop_i) begin
         sel_o = Q_HI;
         why_o = WHY_LOWDROP;
      end else if (old_i) begin
         sel_o = Q_HI;
         why_o = WHY_OLD;
      end else if (young_i && lo_cong_i) begin
         sel_o = Q_LO;
         why_o = WHY_CONGEST;
      end else if (lo_full_i) begin
         sel_o = Q_LO;
         why_o = WHY_FULL;
      end else begin
         sel_o = rr_want_lo_i ? Q_LO : Q_HI;
         why_o = WHY_RR;
      end
   end
endmodule

// File: rtl/egress_two_q_sched.sv
module egress_two_q_sched
   import dqs_pkg::*;
#(
   parameter int TIME_W     = 16,
   parameter int WEIGHT_W   = 5,
   parameter int WEIGHT_MAX = 16,
   parameter int YOUNG_US   = 1000,
   parameter int OLD_US     = 2000
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [WEIGHT_W-1:0] cfg_hi_weight,
   input  logic                tx_req,
   input  logic                hi_nonempty,
   input  logic                lo_nonempty,
   input  logic                hi_low_drop,
   input  logic                lo_congested,
   input  logic                lo_full,
   input  logic [TIME_W-1:0]   hi_head_stamp,
   input  logic [TIME_W-1:0]   time_now,
   output logic                grant_valid,
   output logic                grant_sel
);
   logic  young, old;
   logic  rr_want_lo;
   logic  pick_any;
   qsel_e pick_sel;
   why_e  pick_why;
   logic  fire, took_hi, took_lo;

   dqs_head_age #(
      .TIME_W  (TIME_W),
      .YOUNG_US(YOUNG_US),
      .OLD_US  (OLD_US)
   ) u_age (
      .now_i  (time_now),
      .stamp_i(hi_head_stamp),
      .young_o(young),
      .old_o  (old)
   );

   dqs_rr_count #(
      .WEIGHT_W  (WEIGHT_W),
      .WEIGHT_MAX(WEIGHT_MAX)
   ) u_rr (
      .clk         (clk),
      .rst         (rst),
      .cfg_weight_i(cfg_hi_weight),
      .took_hi_i   (took_hi),
      .took_lo_i   (took_lo),
      .want_lo_o   (rr_want_lo)
   );

   dqs_pick u_pick (
      .hi_ne_i      (hi_nonempty),
      .lo_ne_i      (lo_nonempty),
      .hi_low_drop_i(hi_low_drop),
      .lo_cong_i    (lo_congested),
      .lo_full_i    (lo_full),
      .young_i      (young),
      .old_i        (old),
      .rr_want_lo_i (rr_want_lo),
      .any_o        (pick_any),
      .sel_o        (pick_sel),
      .why_o        (pick_why)
   );

   assign fire    = tx_req & pick_any;
   assign took_hi = fire & (pick_sel == Q_HI);
   assign took_lo = fire & (pick_sel == Q_LO);

   always_ff @(posedge clk) begin
      if (rst) begin
         grant_valid <= 1'b0;
         grant_sel   <= 1'b0;
      end else begin
         grant_valid <= fire;
         if (fire) begin
            grant_sel <= pick_sel;
         end
      end
   end

   AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
      grant_valid |-> $past(tx_req)); // R10
   AST_HI_NOT_EMPTY: assert property (@(posedge clk) disable iff (rst)
      (grant_valid && !grant_sel) |-> $past(hi_nonempty)); // R4
   AST_LO_NOT_EMPTY: assert property (@(posedge clk) disable iff (rst)
      (grant_valid && grant_sel) |-> $past(lo_nonempty)); // R4
   AST_OLD_HEAD_SERVED: assert property (@(posedge clk) disable iff (rst)
      (tx_req && hi_nonempty && old) |=> (grant_valid && !grant_sel)); // R6
   AST_LOWDROP_SERVED: assert property (@(posedge clk) disable iff (rst)
      (tx_req && hi_nonempty && hi_low_drop) |=> (grant_valid && !grant_sel)); // R5
   AST_WHY_CONSISTENT: assert property (@(posedge clk) disable iff (rst)
      (pick_why == WHY_NONE) == !pick_any); // R4
endmodule

// File: tb/egress_two_q_sched_test.sv
module egress_two_q_sched_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [4:0]  cfg_hi_weight = '0;
   logic        tx_req = 1'b0;
   logic        hi_nonempty = 1'b0;
   logic        lo_nonempty = 1'b0;
   logic        hi_low_drop = 1'b0;
   logic        lo_congested = 1'b0;
   logic        lo_full = 1'b0;
   logic [15:0] hi_head_stamp = '0;
   logic [15:0] time_now = '0;
   logic        grant_valid;
   logic        grant_sel;

   int n_tests = 0;
   int n_fail  = 0;
   int mdl_w   = 0;
   int mdl_cnt = 0;
   bit done    = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   egress_two_q_sched uut (
      .clk          (clk),
      .rst          (rst),
      .cfg_hi_weight(cfg_hi_weight),
      .tx_req       (tx_req),
      .hi_nonempty  (hi_nonempty),
      .lo_nonempty  (lo_nonempty),
      .hi_low_drop  (hi_low_drop),
      .lo_congested (lo_congested),
      .lo_full      (lo_full),
      .hi_head_stamp(hi_head_stamp),
      .time_now     (time_now),
      .grant_valid  (grant_valid),
      .grant_sel    (grant_sel)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic do_reset(input int w);
      @(negedge clk);
      rst = 1'b1;
      cfg_hi_weight = 5'(w);
      tx_req = 1'b0;
      repeat (3) @(negedge clk);
      check(grant_valid == 1'b0, "R1 valid low in reset", int'(grant_valid), 0);
      rst = 1'b0;
      cfg_hi_weight = 5'd7;
      mdl_w = (w > 16) ? 16 : w;
      mdl_cnt = 0;
      @(negedge clk);
      check(grant_valid == 1'b0, "R1 valid low after reset", int'(grant_valid), 0);
   endtask

   task automatic set_age(input int age, input logic [15:0] base);
      time_now = base;
      hi_head_stamp = base - 16'(age);
   endtask

   // Expected grant from the requirements: returns {valid, sel}
   function automatic logic [1:0] expect_grant(input int age, output string tag);
      if (!hi_nonempty && !lo_nonempty) begin
         tag = "R4 both empty";
         return 2'b00;
      end
      if (!lo_nonempty) begin tag = "R4 only high"; return 2'b10; end
      if (!hi_nonempty) begin tag = "R4 only low";  return 2'b11; end
      if (hi_low_drop)  begin tag = "R5 low drop";  return 2'b10; end
      if (age >= 2000)  begin tag = "R6 old head";  return 2'b10; end
      if (age < 1000 && lo_congested) begin tag = "R7 congested"; return 2'b11; end
      if (lo_full)      begin tag = "R8 full";      return 2'b11; end
      tag = (mdl_w == 0) ? "R3 zero weight" : "R2 round robin";
      return (mdl_cnt >= mdl_w) ? 2'b11 : 2'b10;
   endfunction

   task automatic request(input int age, input string extra);
      logic [1:0] e;
      string tag;
      e = expect_grant(age, tag);
      @(negedge clk);
      tx_req = 1'b1;
      @(negedge clk);
      tx_req = 1'b0;
      check(grant_valid == e[1], {tag, extra, " valid"}, int'(grant_valid), int'(e[1]));
      if (e[1]) begin
         check(grant_sel == e[0], {tag, extra, " sel"}, int'(grant_sel), int'(e[0]));
         if (e[0]) mdl_cnt = 0;
         else if (mdl_cnt < mdl_w) mdl_cnt++;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      // R2 R3: weight sweep 0..16 with both queues backlogged
      for (int w = 0; w <= 16; w++) begin
         do_reset(w);
         hi_nonempty = 1'b1; lo_nonempty = 1'b1;
         hi_low_drop = 1'b0; lo_congested = 1'b0; lo_full = 1'b0;
         set_age(0, 16'h0100);
         for (int k = 0; k < 2 * (w + 1) + 1; k++) request(0, " sweep");
      end

      // R11: weight captured during reset, clamp above 16
      do_reset(2);
      cfg_hi_weight = 5'd9;
      hi_nonempty = 1'b1; lo_nonempty = 1'b1;
      for (int k = 0; k < 6; k++) request(0, " R11 held weight");
      do_reset(31);
      for (int k = 0; k < 18; k++) request(0, " R11 clamp");

      // R10: single-cycle pulse and no grant without a request
      request(0, " R10");
      @(negedge clk);
      check(grant_valid == 1'b0, "R10 pulse one cycle", int'(grant_valid), 0);
      repeat (4) @(negedge clk);
      check(grant_valid == 1'b0, "R10 no req no grant", int'(grant_valid), 0);

      // R4: empty queues with weights that would otherwise pick them
      do_reset(0);
      hi_nonempty = 1'b1; lo_nonempty = 1'b0;
      for (int k = 0; k < 3; k++) request(0, "");
      do_reset(16);
      hi_nonempty = 1'b0; lo_nonempty = 1'b1;
      for (int k = 0; k < 3; k++) request(0, "");
      hi_nonempty = 1'b0; lo_nonempty = 1'b0;
      request(0, "");

      // R5 R6 R7 R8: age boundaries against every flag combination
      do_reset(3);
      hi_nonempty = 1'b1; lo_nonempty = 1'b1;
      begin
         int ages [8] = '{0, 500, 999, 1000, 1500, 1999, 2000, 3000};
         for (int a = 0; a < 8; a++) begin
            for (int f = 0; f < 8; f++) begin
               hi_low_drop  = f[0];
               lo_congested = f[1];
               lo_full      = f[2];
               set_age(ages[a], 16'h4000 + 16'(a * 37));
               request(ages[a], " age sweep");
            end
         end
      end
      hi_low_drop = 1'b0; lo_congested = 1'b0; lo_full = 1'b0;

      // R9: wrapped time counter
      do_reset(4);
      hi_nonempty = 1'b1; lo_nonempty = 1'b1;
      time_now = 16'h0100; hi_head_stamp = 16'hFF00;  // age 512
      lo_congested = 1'b1;
      request(512, " R9 wrap young");
      lo_congested = 1'b0; lo_full = 1'b1;
      time_now = 16'h0400; hi_head_stamp = 16'hFC00;  // age 2048
      request(2048, " R9 wrap old");
      lo_full = 1'b0;

      // R12: override grants move the count
      do_reset(4);
      set_age(0, 16'h2000);
      request(0, " R12 pre");
      request(0, " R12 pre");
      lo_congested = 1'b1;
      request(0, " R12 forced low");
      lo_congested = 1'b0;
      for (int k = 0; k < 5; k++) request(0, " R12 after low");
      hi_low_drop = 1'b1;
      for (int k = 0; k < 6; k++) request(0, " R12 saturate");
      hi_low_drop = 1'b0;
      request(0, " R12 low after saturate");

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule